// File: doc/BRIEF.md
# Operand Dependence Interlock with Bypass Selection

This block is the dependence logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory access, write-back). Each cycle it compares the register numbers that the decoding instruction and the executing instruction read against the destinations still in flight. Where a result already exists in a later pipeline register, it steers each ALU operand to that result. The only case forwarding cannot cover is a load whose value is needed by the very next instruction. For that case it holds the fetch address and the decode register for one cycle and turns the instruction entering execute into an inert bubble.

A thin shell of pipeline registers carries only the register-number and control fields of each instruction. This lets a surrounding datapath, or a test stimulus, feed the block decoded instruction fields at fetch. The block returns four results: the hold for the program counter and decode register, the control-clear for the execute register, and one bypass select for each ALU operand. Register 0 always reads as zero. The register file is assumed to pass write-back data to a read in the same cycle, so a dependence three instructions apart needs no path here.

Top module: `hzd_interlock`

## Requirements
- R1: During and straight after a synchronous active-high reset, all pipeline registers are empty. pc_hold and idex_flush are 0, and both bypass selects are 0.
- R2: Bypass select encoding: 0 = register file, 1 = the execute/memory register, 2 = the memory/write-back register. An operand of the executing instruction that names the destination of the instruction one step ahead (which writes and is not a load) selects 1, and no stall occurs.
- R3: An operand that names a destination written by the instruction two steps ahead, with no nearer match, selects 2.
- R4: When both later registers hold a write to the operand's register, the nearer (younger) one wins and the select is 1.
- R5: Register 0 never gives a bypass match and never causes a stall, even when an instruction names it as its destination with write enabled.
- R6: When the instruction in decode reads the destination of a load in execute, pc_hold and idex_flush are both 1 for exactly one cycle.
- R7: While held, the decode register keeps its contents. After the bubble, the dependent instruction reaches execute and takes the loaded value with select 2.
- R8: A bubble writes no register and is no load, so no later operand bypasses from it.
- R9: The two operands are checked independently. An instruction that reads one pending register in both operands, or a store whose base register is pending, gets a correct select on each operand.
- R10: An instruction whose register write is disabled is never a bypass source, whatever its destination field holds.
- R11: A load in the execute/memory register is never selected. A load with one unrelated instruction between it and its user causes no stall and is bypassed with select 2.
- R12: An instruction in execute that is not a load never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fet_rs1 | input | 5 | First source register of the fetched instruction |
| fet_rs2 | input | 5 | Second source register (store data or base) of the fetched instruction |
| fet_rd | input | 5 | Destination register of the fetched instruction |
| fet_wr | input | 1 | Fetched instruction writes its destination |
| fet_ld | input | 1 | Fetched instruction is a load |
| pc_hold | output | 1 | Keep the program counter and decode register this cycle |
| idex_flush | output | 1 | Clear control fields of the instruction entering execute |
| byp_a | output | 2 | Bypass select for the first ALU operand |
| byp_b | output | 2 | Bypass select for the second ALU operand |

## Verification
The hardest situation to reach from the ports is the cycle after a load-use bubble. Then the bubble sits in execute with the dependent instruction's source fields, the load sits in the execute/memory register, and the held instruction has to arrive one cycle later and pick up the load from the write-back side. The stimulus reaches it with back-to-back load and user pairs: once through the first operand, once through only the second, once with a load feeding another load's address, and once with a store base. A behavioural model advances its own view of the pipeline from its own expected stalls and checks every output on every cycle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    parameter int REG_W = 5;
    localparam int NREG = 1 << REG_W;
    localparam int NSRC = 2;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        SEL_RF    = 2'd0,
        SEL_EXMEM = 2'd1,
        SEL_MEMWB = 2'd2
    } byp_sel_e;

    typedef struct packed {
        reg_idx_t rs1;
        reg_idx_t rs2;
    } srcs_t;

    typedef struct packed {
        reg_idx_t rd;
        logic     wr;
        logic     ld;
    } dst_t;

    typedef struct packed {
        srcs_t src;
        dst_t  dst;
    } slot_t;

    // True when the pending destination will write register r (r0 excluded).
    function automatic logic pend_write(dst_t d, reg_idx_t r);
        return d.wr && (d.rd != '0) && (d.rd == r);
    endfunction

endpackage

// File: rtl/hzd_pipe_regs.sv
module hzd_pipe_regs
    import hzd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t fetch,
    input  logic  hold,
    input  logic  clear,
    output slot_t ifid,
    output slot_t idex,
    output dst_t  exmem,
    output dst_t  memwb
);

    slot_t bubble;

    always_comb begin
        bubble        = ifid;
        bubble.dst.wr = 1'b0;
        bubble.dst.ld = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ifid  <= '0;
            idex  <= '0;
            exmem <= '0;
            memwb <= '0;
        end else begin
            if (!hold) begin
                ifid <= fetch;
            end
            idex  <= clear ? bubble : ifid;
            exmem <= idex.dst;
            memwb <= exmem;
        end
    end

    // R7: a held decode register keeps its contents
    p_ifid_held_r7: assert property (@(posedge clk) disable iff (rst)
        hold |=> (ifid == $past(ifid)));

    // R8: a bubble enters execute with no write and no load
    p_bubble_inert_r8: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!idex.dst.wr && !idex.dst.ld));

endmodule

// File: rtl/hzd_loaduse.sv
module hzd_loaduse
    import hzd_pkg::*;
(
    input  srcs_t dec_src,
    input  dst_t  ex_dst,
    output logic  stall
);

    logic hit1, hit2;

    always_comb begin
        hit1  = pend_write(ex_dst, dec_src.rs1);
        hit2  = pend_write(ex_dst, dec_src.rs2);
        stall = ex_dst.ld && (hit1 || hit2);
    end

endmodule

// File: rtl/hzd_bypass_sel.sv
module hzd_bypass_sel
    import hzd_pkg::*;
(
    input  reg_idx_t src,
    input  dst_t     near_dst,
    input  dst_t     far_dst,
    output byp_sel_e sel
);

    always_comb begin
        if (pend_write(near_dst, src) && !near_dst.ld) begin
            sel = SEL_EXMEM;
        end else if (pend_write(far_dst, src)) begin
            sel = SEL_MEMWB;
        end else begin
            sel = SEL_RF;
        end
    end

endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock
    import hzd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] fet_rs1,
    input  logic [4:0] fet_rs2,
    input  logic [4:0] fet_rd,
    input  logic       fet_wr,
    input  logic       fet_ld,
    output logic       pc_hold,
    output logic       idex_flush,
    output logic [1:0] byp_a,
    output logic [1:0] byp_b
);

    slot_t    fetch;
    slot_t    ifid;
    slot_t    idex;
    dst_t     exmem;
    dst_t     memwb;
    logic     stall;
    reg_idx_t op_src [NSRC];
    byp_sel_e op_sel [NSRC];

    always_comb begin
        fetch.src.rs1 = fet_rs1;
        fetch.src.rs2 = fet_rs2;
        fetch.dst.rd  = fet_rd;
        fetch.dst.wr  = fet_wr;
        fetch.dst.ld  = fet_ld;
        op_src[0]     = idex.src.rs1;
        op_src[1]     = idex.src.rs2;
    end

    hzd_pipe_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .fetch (fetch),
        .hold  (stall),
        .clear (stall),
        .ifid  (ifid),
        .idex  (idex),
        .exmem (exmem),
        .memwb (memwb)
    );

    hzd_loaduse u_lu (
        .dec_src (ifid.src),
        .ex_dst  (idex.dst),
        .stall   (stall)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_op
        hzd_bypass_sel u_sel (
            .src      (op_src[g]),
            .near_dst (exmem),
            .far_dst  (memwb),
            .sel      (op_sel[g])
        );
    end

    assign pc_hold    = stall;
    assign idex_flush = stall;
    assign byp_a      = op_sel[0];
    assign byp_b      = op_sel[1];

    // R6: a load-use interlock lasts one cycle only
    p_single_bubble_r6: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    // R5: register 0 is always read from the register file
    p_r0_rf_a_r5: assert property (@(posedge clk) disable iff (rst)
        (idex.src.rs1 == '0) |-> (byp_a == 2'd0));
    p_r0_rf_b_r5: assert property (@(posedge clk) disable iff (rst)
        (idex.src.rs2 == '0) |-> (byp_b == 2'd0));

    // R11: a load still in the memory stage is never a bypass source
    p_no_early_load_r11: assert property (@(posedge clk) disable iff (rst)
        ((byp_a == 2'd1) || (byp_b == 2'd1)) |-> !exmem.ld);

    // R10: only a writing instruction is a bypass source
    p_src_writes_r10: assert property (@(posedge clk) disable iff (rst)
        ((byp_a == 2'd2) || (byp_b == 2'd2)) |-> memwb.wr);

endmodule

// File: tb/hzd_interlock_bench.sv
`timescale 1ns/1ps
module hzd_interlock_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] f_rs1, f_rs2, f_rd;
    logic       f_wr, f_ld;
    logic       pc_hold, idex_flush;
    logic [1:0] byp_a, byp_b;

    always #4 clk = ~clk;

    hzd_interlock u_hzd_interlock (
        .clk        (clk),
        .rst        (rst),
        .fet_rs1    (f_rs1),
        .fet_rs2    (f_rs2),
        .fet_rd     (f_rd),
        .fet_wr     (f_wr),
        .fet_ld     (f_ld),
        .pc_hold    (pc_hold),
        .idex_flush (idex_flush),
        .byp_a      (byp_a),
        .byp_b      (byp_b)
    );

    typedef struct {
        int rs1; int rs2; int rd; bit wr; bit ld; bit bub;
    } ins_t;

    ins_t prog[$];
    ins_t older[$];   // [0] execute, [1] memory, [2] write-back
    ins_t dec_m;
    int   pc;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;

    function automatic ins_t mk(int a, int b, int d, bit w, bit l);
        ins_t t;
        t.rs1 = a; t.rs2 = b; t.rd = d; t.wr = w; t.ld = l; t.bub = 0;
        return t;
    endfunction

    function automatic bit hits(ins_t p, int r);
        return p.wr && p.rd != 0 && p.rd == r;
    endfunction

    function automatic int exp_sel(int r);
        if (hits(older[1], r) && !older[1].ld) return 1;
        if (hits(older[2], r)) return 2;
        return 0;
    endfunction

    function automatic bit exp_stall();
        return older[0].ld && (hits(older[0], dec_m.rs1) || hits(older[0], dec_m.rs2));
    endfunction

    function automatic string tag_sel(int r, int e);
        if (r == 0) return "R5";
        if (e == 1 && hits(older[2], r)) return "R4";
        if (e == 1) return "R2";
        if (e == 2 && older[1].bub) return "R7";
        if (e == 2 && older[2].ld) return "R11";
        if (e == 2) return "R3";
        if (older[1].ld && older[1].rd == r) return "R11";
        if ((older[1].bub && older[1].rd == r) || (older[2].bub && older[2].rd == r)) return "R8";
        if ((!older[1].wr && older[1].rd == r) || (!older[2].wr && older[2].rd == r)) return "R10";
        return "R9";
    endfunction

    task automatic chk(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        ins_t z;
        ins_t cur;
        bit   eh;
        z = mk(0, 0, 0, 0, 0);
        prog.push_back(mk(2, 3, 1, 1, 0));   // write r1
        prog.push_back(mk(1, 1, 4, 1, 0));   // R9: r1 in both operands
        prog.push_back(mk(1, 4, 5, 1, 0));   // R3 on r1, R2 on r4
        prog.push_back(mk(9, 0, 9, 1, 0));
        prog.push_back(mk(0, 0, 9, 1, 0));
        prog.push_back(mk(9, 9, 12, 1, 0));  // R4: two pending writes of r9
        prog.push_back(mk(2, 0, 6, 1, 1));   // load r6
        prog.push_back(mk(6, 3, 13, 1, 0));  // R6 stall, then R7
        prog.push_back(mk(3, 0, 7, 1, 1));   // load r7
        prog.push_back(z);
        prog.push_back(mk(2, 7, 14, 1, 0));  // R11: gap of one, no stall
        prog.push_back(mk(0, 0, 0, 1, 1));   // load to r0
        prog.push_back(mk(0, 0, 15, 1, 0));  // R5: no stall
        prog.push_back(mk(2, 3, 8, 0, 0));   // store, rd field 8 unwritten
        prog.push_back(mk(8, 8, 16, 1, 0));  // R10: no bypass of r8
        prog.push_back(mk(1, 0, 10, 1, 1));  // load r10
        prog.push_back(mk(3, 10, 17, 1, 0)); // R9: stall via second operand
        prog.push_back(mk(0, 0, 11, 1, 1));  // load r11
        prog.push_back(mk(11, 0, 11, 0, 0)); // store with pending base r11
        prog.push_back(mk(11, 11, 0, 0, 0));
        prog.push_back(mk(17, 0, 0, 0, 0));
        prog.push_back(mk(2, 0, 18, 1, 1));  // load r18
        prog.push_back(mk(18, 0, 19, 1, 1)); // load addressed by r18
        prog.push_back(mk(19, 19, 20, 1, 0));
        prog.push_back(mk(20, 5, 21, 1, 0)); // R12 after non-load

        f_rs1 = 0; f_rs2 = 0; f_rd = 0; f_wr = 0; f_ld = 0;
        older = {z, z, z};
        dec_m = z;
        pc = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", pc_hold, 0);
        chk("R1", idex_flush, 0);
        chk("R1", byp_a, 0);
        chk("R1", byp_b, 0);

        for (int cyc = 0; cyc < prog.size() + 12; cyc++) begin
            eh = exp_stall();
            if (eh) begin
                chk("R6", pc_hold, 1);
                chk("R6", idex_flush, 1);
            end else begin
                chk(older[0].ld ? "R5" : "R12", pc_hold, 0);
                chk(older[0].ld ? "R5" : "R12", idex_flush, 0);
            end
            chk(tag_sel(older[0].rs1, exp_sel(older[0].rs1)), byp_a, exp_sel(older[0].rs1));
            chk(tag_sel(older[0].rs2, exp_sel(older[0].rs2)), byp_b, exp_sel(older[0].rs2));
            cur = (pc < prog.size()) ? prog[pc] : z;
            f_rs1 = cur.rs1[4:0]; f_rs2 = cur.rs2[4:0]; f_rd = cur.rd[4:0];
            f_wr = cur.wr; f_ld = cur.ld;
            @(posedge clk);
            #1;
            begin
                ins_t nx;
                nx = dec_m;
                if (eh) begin
                    nx.wr = 0; nx.ld = 0; nx.bub = 1;
                end
                older.push_front(nx);
                void'(older.pop_back());
                if (!eh) begin
                    dec_m = cur;
                    pc++;
                end
            end
            @(negedge clk);
        end
        if (!finished) begin
            summary();
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule